// File: doc/BRIEF.md
# Target Presence Polling Engine

This block sits on the controller side of a two-wire serial bus. It keeps addressing one target device until that device acknowledges. It runs only while the controller is set as bus master and the presence-monitor control bit is on. When both are on, a write strobe on the address input latches a target address and starts polling.

Each attempt hands the address to an address-phase sequencer through a request/done handshake. The sequencer then reports whether the target acknowledged. After a refusal (NACK), the engine waits a programmable pause before it tries again. The pause is a 4-bit value N and lasts N+1 bus clock ticks. After an acknowledge, the engine raises a one-cycle ready pulse and goes back to idle. If either enable bit is cleared while polling, the engine abandons the attempt quietly.

Top module: `probe_poller`

## Requirements
- R1: After reset the engine is idle: `seqReq`, `readyPulse` and `busy` are 0, and `seqAddr` is 0.
- R2: A clock edge that samples `addrWr`=1 while idle with `masterEn`=1 and `monitorEn`=1 makes `seqReq` and `busy` 1 from the next cycle. If either enable is 0, the strobe is ignored and the engine stays idle.
- R3: A clock edge that samples `seqReq`=1 and `seqDone`=1 with `seqAck`=0 starts a pause and drops `seqReq` on the next cycle. The pause loads the `pauseVal` value present at that edge. `seqReq` returns after exactly `pauseVal`+1 edges that sample `busTick`=1. With `pauseVal`=0, the first tick starts the retry.
- R4: A clock edge that samples `seqReq`=1 and `seqDone`=1 with `seqAck`=1 produces `readyPulse`=1 for exactly one cycle, with `seqReq`=0. The engine is idle (`busy`=0) in the cycle after.
- R5: An edge that samples `masterEn`=0 or `monitorEn`=0 while the engine is requesting or pausing returns it to idle without a ready pulse. This takes priority over an acknowledge sampled at the same edge.
- R6: The address mode is taken at the starting write. With `shortAddr`=1, `seqAddr` carries `addrIn[6:0]` with bits 9:7 forced to 0, and `seqTenBit`=0. With `shortAddr`=0, `seqAddr` carries all of `addrIn[9:0]`, and `seqTenBit`=1.
- R7: An `addrWr` strobe while the engine is busy changes neither `seqAddr` nor the polling sequence.
- R8: `seqDone` sampled while not requesting, and `busTick` sampled while not pausing, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterEn | input | 1 | Controller acts as bus master |
| monitorEn | input | 1 | Presence-monitor mode enable |
| shortAddr | input | 1 | 1 = 7-bit address, 0 = 10-bit address |
| addrWr | input | 1 | Address register write strobe |
| addrIn | input | 10 | Address written with the strobe |
| pauseVal | input | 4 | Pause length minus one, in bus ticks |
| busTick | input | 1 | One-cycle bus clock tick enable |
| seqReq | output | 1 | Address-phase request to the sequencer |
| seqAddr | output | 10 | Target address for the sequencer |
| seqTenBit | output | 1 | Sequencer must use 10-bit addressing |
| seqDone | input | 1 | Sequencer finished the address phase |
| seqAck | input | 1 | Target acknowledged (valid with seqDone) |
| readyPulse | output | 1 | Target-ready flag, one cycle |
| busy | output | 1 | Polling in progress |

## Verification
The sharpest collision is an enable bit dropping at the same edge where the sequencer reports an acknowledge. The bench provokes it by clearing `masterEn` together with `seqDone`/`seqAck`. It then judges that no ready pulse appears and that the engine is idle in the next cycle. A second collision is a disable landing on the very tick that would end a pause: the engine must go idle and not issue a new request. The behavioural model in the bench settles the expected outcome of both, and the outputs are compared against it on every clock.

// File: rtl/probe_pkg.sv
package probe_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_ADDR = 2'd1,
    PS_WAIT = 2'd2,
    PS_DONE = 2'd3
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic loadPause;
    logic decPause;
  } dpCtl_t;
endpackage

// File: rtl/probe_ctrl.sv
module probe_ctrl
  import probe_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   masterEn,
  input  logic   monitorEn,
  input  logic   addrWr,
  input  logic   busTick,
  input  logic   seqDone,
  input  logic   seqAck,
  input  logic   pauseZero,
  output dpCtl_t ctl,
  output logic   seqReq,
  output logic   readyPulse,
  output logic   busy
);
  pollState_t stateQ, stateD;
  logic enOk;

  assign enOk = masterEn & monitorEn;

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      PS_IDLE: if (addrWr && enOk) begin
        stateD       = PS_ADDR;
        ctl.loadAddr = 1'b1;
      end
      PS_ADDR: begin
        if (!enOk) stateD = PS_IDLE;
        else if (seqDone) begin
          if (seqAck) stateD = PS_DONE;
          else begin
            stateD        = PS_WAIT;
            ctl.loadPause = 1'b1;
          end
        end
      end
      PS_WAIT: begin
        if (!enOk) stateD = PS_IDLE;
        else if (busTick) begin
          if (pauseZero) stateD = PS_ADDR;
          else ctl.decPause = 1'b1;
        end
      end
      PS_DONE: stateD = PS_IDLE;
      default: stateD = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= PS_IDLE;
    else       stateQ <= stateD;
  end

  assign seqReq     = (stateQ == PS_ADDR);
  assign readyPulse = (stateQ == PS_DONE);
  assign busy       = (stateQ != PS_IDLE);
endmodule

// File: rtl/probe_dp.sv
module probe_dp
  import probe_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int SHORT_W = 7,
  parameter int PAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic               shortAddr,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic [PAUSE_W-1:0] pauseVal,
  output logic [ADDR_W-1:0]  seqAddr,
  output logic               seqTenBit,
  output logic               pauseZero
);
  localparam int HI_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0]  addrQ, addrSel;
  logic               tenQ;
  logic [PAUSE_W-1:0] cntQ;

  generate
    if (HI_W > 0) begin : g_mask
      assign addrSel = shortAddr ? {{HI_W{1'b0}}, addrIn[SHORT_W-1:0]} : addrIn;
    end else begin : g_nomask
      assign addrSel = addrIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      tenQ  <= 1'b0;
    end else if (ctl.loadAddr) begin
      addrQ <= addrSel;
      tenQ  <= ~shortAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= '0;
    else if (ctl.loadPause) cntQ <= pauseVal;
    else if (ctl.decPause)  cntQ <= cntQ - 1'b1;
  end

  assign seqAddr   = addrQ;
  assign seqTenBit = tenQ;
  assign pauseZero = (cntQ == '0);
endmodule

// File: rtl/probe_poller.sv
module probe_poller
  import probe_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int SHORT_W = 7,
  parameter int PAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               masterEn,
  input  logic               monitorEn,
  input  logic               shortAddr,
  input  logic               addrWr,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic [PAUSE_W-1:0] pauseVal,
  input  logic               busTick,
  output logic               seqReq,
  output logic [ADDR_W-1:0]  seqAddr,
  output logic               seqTenBit,
  input  logic               seqDone,
  input  logic               seqAck,
  output logic               readyPulse,
  output logic               busy
);
  dpCtl_t ctl;
  logic   pauseZero;

  probe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .monitorEn(monitorEn),
    .addrWr(addrWr), .busTick(busTick), .seqDone(seqDone), .seqAck(seqAck),
    .pauseZero(pauseZero), .ctl(ctl), .seqReq(seqReq),
    .readyPulse(readyPulse), .busy(busy)
  );

  probe_dp #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .PAUSE_W(PAUSE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .shortAddr(shortAddr),
    .addrIn(addrIn), .pauseVal(pauseVal), .seqAddr(seqAddr),
    .seqTenBit(seqTenBit), .pauseZero(pauseZero)
  );
endmodule

// File: rtl/probe_poller_chk.sv
module probe_poller_chk #(
  parameter int ADDR_W  = 10,
  parameter int SHORT_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterEn,
  input logic              monitorEn,
  input logic              addrWr,
  input logic              seqReq,
  input logic [ADDR_W-1:0] seqAddr,
  input logic              seqTenBit,
  input logic              seqDone,
  input logic              seqAck,
  input logic              readyPulse,
  input logic              busy
);
  // R2
  start_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && addrWr && masterEn && monitorEn) |=> (seqReq && busy));

  // R3
  nack_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqReq && seqDone && !seqAck && masterEn && monitorEn) |=> (!seqReq && busy && !readyPulse));

  // R4
  ready_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |=> (!readyPulse && !busy));

  // R4
  ready_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |-> !seqReq);

  // R5
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !readyPulse && !(masterEn && monitorEn)) |=> (!busy && !readyPulse));

  // R6
  short_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqReq && !seqTenBit) |-> (seqAddr[ADDR_W-1:SHORT_W] == '0));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(seqAddr) && $stable(seqTenBit)));
endmodule

bind probe_poller probe_poller_chk #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_chk (
  .clk(clk), .rstN(rstN), .masterEn(masterEn), .monitorEn(monitorEn),
  .addrWr(addrWr), .seqReq(seqReq), .seqAddr(seqAddr), .seqTenBit(seqTenBit),
  .seqDone(seqDone), .seqAck(seqAck), .readyPulse(readyPulse), .busy(busy)
);

// File: tb/probe_poller_tb.sv
`timescale 1ns/1ps
module probe_poller_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterEn = 0, monitorEn = 0, shortAddr = 1, addrWr = 0;
  logic [9:0] addrIn = '0;
  logic [3:0] pauseVal = '0;
  logic       busTick = 0, seqDone = 0, seqAck = 0;
  logic       seqReq, seqTenBit, readyPulse, busy;
  logic [9:0] seqAddr;

  int errors = 0, checks = 0, cyc = 0, readySeen = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  probe_poller u_dut (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .monitorEn(monitorEn),
    .shortAddr(shortAddr), .addrWr(addrWr), .addrIn(addrIn), .pauseVal(pauseVal),
    .busTick(busTick), .seqReq(seqReq), .seqAddr(seqAddr), .seqTenBit(seqTenBit),
    .seqDone(seqDone), .seqAck(seqAck), .readyPulse(readyPulse), .busy(busy)
  );

  // behavioural reference: phase string plus remaining-tick count
  string mPhase = "idle";
  int    mTicksLeft = 0;
  int    mAddr = 0;
  bit    mTen = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = "idle"; mAddr = 0; mTen = 0; mTicksLeft = 0;
    end else begin
      bool_step();
    end
  end

  task automatic bool_step();
    bit on = masterEn && monitorEn;
    if (mPhase == "idle") begin
      if (addrWr && on) begin
        mPhase = "req";
        mTen   = !shortAddr;
        mAddr  = shortAddr ? (int'(addrIn) % 128) : int'(addrIn);
      end
    end else if (mPhase == "ready") begin
      mPhase = "idle";
    end else if (!on) begin
      mPhase = "idle";
    end else if (mPhase == "req") begin
      if (seqDone && seqAck) mPhase = "ready";
      else if (seqDone) begin mPhase = "pause"; mTicksLeft = int'(pauseVal) + 1; end
    end else if (mPhase == "pause") begin
      if (busTick) begin
        mTicksLeft--;
        if (mTicksLeft == 0) mPhase = "req";
      end
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // compare all outputs against the model, away from the edge
  task automatic step();
    @(negedge clk);
    cyc++;
    chk("R2/R3 seqReq", int'(seqReq), int'(mPhase == "req"));
    chk("R4 readyPulse", int'(readyPulse), int'(mPhase == "ready"));
    chk("R5/R8 busy", int'(busy), int'(mPhase != "idle"));
    chk("R6/R7 seqAddr", int'(seqAddr), mAddr);
    chk("R6 seqTenBit", int'(seqTenBit), int'(mTen));
    if (readyPulse) readySeen++;
  endtask

  task automatic idleCycles(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic startPoll(bit shortM, logic [9:0] a);
    shortAddr = shortM; addrIn = a; addrWr = 1; step(); addrWr = 0;
  endtask

  task automatic answer(bit ack);
    seqDone = 1; seqAck = ack; step(); seqDone = 0; seqAck = 0;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      busTick = 1; step(); busTick = 0;
      idleCycles(gap);
    end
  endtask

  initial begin
    idleCycles(2);
    // R1 reset values
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset seqAddr", int'(seqAddr), 0);
    @(negedge clk); rstN = 1;
    idleCycles(2);

    // R2 ignored when monitor off / master off
    masterEn = 1; monitorEn = 0; startPoll(1, 10'h155); idleCycles(1);
    chk("R2 no start w/o monitor", int'(busy), 0);
    masterEn = 0; monitorEn = 1; startPoll(1, 10'h155); idleCycles(1);
    chk("R2 no start w/o master", int'(busy), 0);

    // R6 7-bit address, R3 pause of 3 ticks, R7 write while busy, R8 stray
    masterEn = 1;
    startPoll(1, 10'h3A5);
    chk("R6 short addr", int'(seqAddr), 10'h025);
    busTick = 1; step(); busTick = 0;          // R8 tick during request
    pauseVal = 4'd2; answer(0);
    pauseVal = 4'd9;                           // later changes irrelevant
    seqDone = 1; seqAck = 1; step(); seqDone = 0; seqAck = 0; // R8 done during pause
    startPoll(0, 10'h2F0);                     // R7 ignored
    ticks(2, 1);
    chk("R3 still pausing", int'(seqReq), 0);
    ticks(1, 0);
    chk("R3 retry after N+1", int'(seqReq), 1);
    answer(1);
    chk("R4 ready pulse", int'(readyPulse), 1);
    idleCycles(2);

    // R6 10-bit, R3 pause 0
    pauseVal = 4'd0;
    startPoll(0, 10'h2F3);
    chk("R6 ten-bit addr", int'(seqAddr), 10'h2F3);
    chk("R6 ten-bit flag", int'(seqTenBit), 1);
    answer(0); idleCycles(2);
    ticks(1, 0);
    chk("R3 zero pause retry", int'(seqReq), 1);
    answer(0); ticks(1, 0); answer(1); idleCycles(2);

    // R5 abort in pause, abort on final tick, abort with ack
    pauseVal = 4'd1;
    startPoll(1, 10'h011); answer(0); ticks(1, 0);
    masterEn = 0; step(); masterEn = 1; idleCycles(1);
    chk("R5 abort in pause", int'(busy), 0);
    startPoll(1, 10'h012); answer(0); ticks(1, 0);
    monitorEn = 0; busTick = 1; step(); busTick = 0; monitorEn = 1;
    chk("R5 abort on last tick", int'(seqReq), 0);
    startPoll(1, 10'h013);
    masterEn = 0; answer(1); masterEn = 1;
    chk("R5 abort beats ack", int'(readyPulse), 0);
    idleCycles(2);

    // R3 maximal pause
    pauseVal = 4'hF;
    startPoll(0, 10'h3FF); answer(0);
    ticks(15, 2);
    chk("R3 max pause holding", int'(seqReq), 0);
    ticks(1, 0);
    chk("R3 max pause retry", int'(seqReq), 1);
    answer(1); idleCycles(3);

    chk("R4 ready count", readySeen, 3);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule